// File: doc/BRIEF.md
# Vector-Pull Address Remapper

This block is glue logic for an 8-bit processor with a 16-bit address bus. It watches the processor's two bus-state outputs. While the processor is fetching an interrupt or reset vector, it moves accesses to the top 16 bytes of memory down one 256-byte page into a shadow window of RAM. It does this by clearing a single address bit. At all other times the top 16 bytes are ordinary RAM. A jump table that runs up into that area therefore keeps its normal addresses.

The shadow page is shared with memory-mapped I/O. In normal operation that page selects either the host interface chip or a generic I/O select, and the RAM behind it is reached only by vector fetches. Software can rewrite the relocated vectors by setting a control bit. The control bit lives in the same I/O page, and while it is set the whole page selects RAM. When the processor reports that it has handed the bus to another master, the block drops every chip select and raises a bus-released flag.

All decoding is combinational from the address and the bus state. The control bit is the only storage element.

Top module: `vecpull_remap`

## Requirements
- R1: The bus state is `{bus_avail, bus_stat}`, decoded as follows: 2'b00 is run, 2'b01 is vector fetch (interrupt or reset acknowledge), 2'b10 is sync acknowledge and 2'b11 is bus released. Run and sync decode identically.
- R2: In state 2'b01, an address in 0xFFF0–0xFFFF drives `ram_addr` equal to the address with bit 8 cleared (0xFEF0–0xFEFF). Only `ram_sel` is asserted.
- R3: In states 2'b00 and 2'b10, and in state 2'b01 for addresses outside 0xFFF0–0xFFFF, no redirection occurs: `ram_addr` equals `cpu_addr`.
- R4: The redirected window is exactly 16 bytes. For example, 0xFFEF in state 2'b01 passes unchanged to RAM.
- R5: Outside state 2'b11, with the control bit clear, addresses 0xFEF8–0xFEFF assert only `host_sel`.
- R6: Outside state 2'b11, with the control bit clear, addresses 0xFEF0–0xFEF7 assert only `io_sel`.
- R7: The control bit is cleared by reset. On a clock edge it loads `cpu_wbit` only when all of the following hold: `cycle_valid` is 1, `cpu_rnw` is 0, the address is 0xFEF0 and the state is 2'b00 or 2'b10. Writes in states 2'b01 or 2'b11, or with `cycle_valid` at 0, leave it unchanged.
- R8: While the control bit is set, addresses 0xFEF0–0xFEFF outside state 2'b11 assert only `ram_sel`, with `ram_addr` equal to `cpu_addr`.
- R9: In state 2'b11, `bus_released` is 1, `ram_sel`, `io_sel` and `host_sel` are all 0, and `ram_addr` follows `cpu_addr`. In every other state `bus_released` is 0.
- R10: Outside state 2'b11, exactly one select is asserted. Addresses outside the 0xFEFx page select RAM.
- R11: A read (`cpu_rnw` = 1) of 0xFEF0 does not change the control bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_wbit | input | 1 | Data line carrying the new control bit value |
| cycle_valid | input | 1 | Qualifies the current bus cycle for a register write |
| bus_avail | input | 1 | Processor bus-available output (upper bit of the state) |
| bus_stat | input | 1 | Processor bus-status output (lower bit of the state) |
| ram_addr | output | 16 | Physical RAM address |
| ram_sel | output | 1 | RAM chip select |
| io_sel | output | 1 | Generic I/O select for 0xFEF0–0xFEF7 |
| host_sel | output | 1 | Host interface chip select for 0xFEF8–0xFEFF |
| bus_released | output | 1 | Processor has released the bus |

## Verification
The control bit is the only hidden state. If it is wrong, the error shows up in the same cycle as the next access to the 0xFEFx page: `ram_sel` appears where `io_sel` or `host_sel` is expected, or the reverse. The bench therefore follows every attempted write, ignored write and reset with such an access. A wrong decode of the bus state shows in the same cycle as a missing bit-8 flip on a 0xFFFx address, or as a select that remains asserted while the bus is released.

// File: rtl/vpr_pkg.sv
// Package: shared types for the vector-pull remapper.
// Assumes the bus-state code is {available, status} as driven by the processor.
package vpr_pkg;

    typedef enum logic [1:0] {
        BST_RUN      = 2'b00,
        BST_VECTOR   = 2'b01,
        BST_SYNC     = 2'b10,
        BST_RELEASED = 2'b11
    } bus_state_e;

    typedef struct packed {
        logic ram;
        logic io;
        logic host;
    } sel_t;

endpackage

// File: rtl/vpr_state_decode.sv
// Module: vpr_state_decode
// Turns the two processor bus-state pins into qualifiers (R1).
// Assumes the pins are stable for the whole bus cycle. Run and sync both count as the
// processor owning the bus for ordinary data accesses.
module vpr_state_decode
    import vpr_pkg::*;
(
    input  logic bus_avail,
    input  logic bus_stat,
    output logic is_vector,
    output logic is_released,
    output logic cpu_owns
);

    bus_state_e state;

    // Classify the bus state code.
    always_comb begin
        state       = bus_state_e'({bus_avail, bus_stat});
        is_vector   = 1'b0;
        is_released = 1'b0;
        cpu_owns    = 1'b0;
        unique case (state)
            BST_RUN,
            BST_SYNC:     cpu_owns    = 1'b1;
            BST_VECTOR:   is_vector   = 1'b1;
            BST_RELEASED: is_released = 1'b1;
        endcase
    end

endmodule

// File: rtl/vpr_ctrl_reg.sv
// Module: vpr_ctrl_reg
// Holds the vector-edit control bit (R7, R11).
// Assumes a write is qualified by cycle_valid with cpu_rnw low and the processor owning the
// bus. The bit is loaded from cpu_wbit on that edge.
module vpr_ctrl_reg #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFEF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cycle_valid,
    input  logic              cpu_rnw,
    input  logic              cpu_owns,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wbit,
    output logic              ctrl_q
);

    logic wr_hit;

    // Qualify a write to the control register address.
    always_comb wr_hit = cycle_valid && !cpu_rnw && cpu_owns && (cpu_addr == CTRL_ADDR);

    // Store the control bit; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (wr_hit)
            ctrl_q <= cpu_wbit;
    end

endmodule

// File: rtl/vpr_addr_map.sv
// Module: vpr_addr_map
// Combinational address map: flips one bit for vector fetches and decodes the shared I/O page.
// Assumes VEC_BASE is aligned to the window size, and that clearing FLIP_BIT of VEC_BASE
// gives the I/O page base.
module vpr_addr_map
    import vpr_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_W    = 4,
    parameter int                FLIP_BIT = 8,
    parameter int                HOST_OFS = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF0
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              is_vector,
    input  logic              is_released,
    input  logic              ctrl_q,
    output logic [ADDR_W-1:0] ram_addr,
    output sel_t              sel
);

    localparam int                TAG_W     = ADDR_W - WIN_W;
    localparam logic [ADDR_W-1:0] FLIP_MASK = ADDR_W'(1) << FLIP_BIT;
    localparam logic [ADDR_W-1:0] IO_BASE   = VEC_BASE & ~FLIP_MASK;
    localparam logic [TAG_W-1:0]  VEC_TAG   = VEC_BASE[ADDR_W-1:WIN_W];
    localparam logic [TAG_W-1:0]  IO_TAG    = IO_BASE[ADDR_W-1:WIN_W];

    logic in_vec_win;
    logic in_io_win;
    logic host_half;
    logic redirect;

    // Window matches on the tag bits above the window offset.
    always_comb begin
        in_vec_win = (cpu_addr[ADDR_W-1:WIN_W] == VEC_TAG);
        in_io_win  = (cpu_addr[ADDR_W-1:WIN_W] == IO_TAG);
        host_half  = (cpu_addr[WIN_W-1:0] >= WIN_W'(HOST_OFS));
        redirect   = is_vector && in_vec_win;
    end

    // Build the RAM address bit by bit; only the flip bit can be cleared.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
        if (i == FLIP_BIT) begin : g_flip
            assign ram_addr[i] = cpu_addr[i] & ~redirect;
        end else begin : g_pass
            assign ram_addr[i] = cpu_addr[i];
        end
    end

    // Pick exactly one select, or none while the bus is released.
    always_comb begin
        sel = '0;
        if (!is_released) begin
            if (!redirect && in_io_win && !ctrl_q) begin
                sel.host = host_half;
                sel.io   = !host_half;
            end else begin
                sel.ram = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vecpull_remap.sv
// Module: vecpull_remap (top)
// Redirects vector fetches from the top window into a RAM page shared with memory-mapped I/O,
// and decodes that page into I/O and host-interface selects.
// Assumes a synchronous active-low reset. Decoding is combinational; the only storage is the
// control bit.
module vecpull_remap
    import vpr_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_W    = 4,
    parameter int                FLIP_BIT = 8,
    parameter int                HOST_OFS = 8,
    parameter int                CTRL_OFS = 0,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rnw,
    input  logic              cpu_wbit,
    input  logic              cycle_valid,
    input  logic              bus_avail,
    input  logic              bus_stat,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_sel,
    output logic              io_sel,
    output logic              host_sel,
    output logic              bus_released
);

    localparam logic [ADDR_W-1:0] IO_BASE   = VEC_BASE & ~(ADDR_W'(1) << FLIP_BIT);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = IO_BASE | ADDR_W'(CTRL_OFS);

    logic is_vector;
    logic is_released;
    logic cpu_owns;
    logic ctrl_q;
    sel_t sel;

    vpr_state_decode u_state (
        .bus_avail   (bus_avail),
        .bus_stat    (bus_stat),
        .is_vector   (is_vector),
        .is_released (is_released),
        .cpu_owns    (cpu_owns)
    );

    vpr_ctrl_reg #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_valid (cycle_valid),
        .cpu_rnw     (cpu_rnw),
        .cpu_owns    (cpu_owns),
        .cpu_addr    (cpu_addr),
        .cpu_wbit    (cpu_wbit),
        .ctrl_q      (ctrl_q)
    );

    vpr_addr_map #(
        .ADDR_W   (ADDR_W),
        .WIN_W    (WIN_W),
        .FLIP_BIT (FLIP_BIT),
        .HOST_OFS (HOST_OFS),
        .VEC_BASE (VEC_BASE)
    ) u_map (
        .cpu_addr    (cpu_addr),
        .is_vector   (is_vector),
        .is_released (is_released),
        .ctrl_q      (ctrl_q),
        .ram_addr    (ram_addr),
        .sel         (sel)
    );

    // Drive the output pins from the decoded selects.
    always_comb begin
        ram_sel      = sel.ram;
        io_sel       = sel.io;
        host_sel     = sel.host;
        bus_released = is_released;
    end

endmodule

// File: rtl/vpr_checker.sv
// Module: vpr_checker
// Property checks for vecpull_remap, attached by bind.
// Assumes the default address map: 16-byte window, flip bit 8, host half from offset 8.
module vpr_checker #(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_W    = 4,
    parameter int                FLIP_BIT = 8,
    parameter int                HOST_OFS = 8,
    parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rnw,
    input logic              cpu_wbit,
    input logic              cycle_valid,
    input logic              bus_avail,
    input logic              bus_stat,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_sel,
    input logic              io_sel,
    input logic              host_sel,
    input logic              bus_released,
    input logic              ctrl_q
);

    localparam logic [ADDR_W-1:0] FMASK  = ADDR_W'(1) << FLIP_BIT;
    localparam logic [ADDR_W-1:0] IOBASE = VEC_BASE & ~FMASK;

    logic [1:0] st;
    logic       in_vec, in_io, hi_half, owns, wr_q;

    // Independent view of state, windows and write qualification.
    always_comb begin
        st      = {bus_avail, bus_stat};
        in_vec  = (cpu_addr >> WIN_W) == (VEC_BASE >> WIN_W);
        in_io   = (cpu_addr >> WIN_W) == (IOBASE >> WIN_W);
        hi_half = cpu_addr[WIN_W-1:0] >= WIN_W'(HOST_OFS);
        owns    = (st == 2'b00) || (st == 2'b10);
        wr_q    = cycle_valid && !cpu_rnw && owns && (cpu_addr == IOBASE);
    end

    assert_vector_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b01 && in_vec) |-> (ram_sel && !io_sel && !host_sel && ram_addr == (cpu_addr & ~FMASK)));

    assert_no_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 2'b11 && !(st == 2'b01 && in_vec)) |-> (ram_addr == cpu_addr));

    assert_host_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (owns && in_io && hi_half && !ctrl_q) |-> (host_sel && !ram_sel && !io_sel));

    assert_io_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (owns && in_io && !hi_half && !ctrl_q) |-> (io_sel && !ram_sel && !host_sel));

    assert_ctrl_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |=> (ctrl_q == $past(cpu_wbit)));

    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_q |=> $stable(ctrl_q));

    assert_edit_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (owns && in_io && ctrl_q) |-> (ram_sel && ram_addr == cpu_addr));

    assert_bus_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 2'b11) |-> (bus_released && !ram_sel && !io_sel && !host_sel));

    assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 2'b11) |-> (!bus_released && $countones({ram_sel, io_sel, host_sel}) == 1));

endmodule

bind vecpull_remap vpr_checker #(
    .ADDR_W   (ADDR_W),
    .WIN_W    (WIN_W),
    .FLIP_BIT (FLIP_BIT),
    .HOST_OFS (HOST_OFS),
    .VEC_BASE (VEC_BASE)
) u_vpr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_rnw      (cpu_rnw),
    .cpu_wbit     (cpu_wbit),
    .cycle_valid  (cycle_valid),
    .bus_avail    (bus_avail),
    .bus_stat     (bus_stat),
    .ram_addr     (ram_addr),
    .ram_sel      (ram_sel),
    .io_sel       (io_sel),
    .host_sel     (host_sel),
    .bus_released (bus_released),
    .ctrl_q       (ctrl_q)
);

// File: tb/vecpull_remap_test.sv
// Bench for vecpull_remap: a table walk with the control bit clear, then directed tests
// for the control bit, reset and ignored writes.
module vecpull_remap_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 18;

    localparam logic [2:0] S_RAM  = 3'b100;
    localparam logic [2:0] S_IO   = 3'b010;
    localparam logic [2:0] S_HOST = 3'b001;
    localparam logic [2:0] S_NONE = 3'b000;

    // Entry layout: {req[3:0], state[1:0], addr[15:0], exp_addr[15:0], exp_sel{ram,io,host}, exp_released}
    typedef logic [41:0] vec_t;
    localparam vec_t TABLE [NVEC] = '{
        {4'd3,  2'b00, 16'hFFFE, 16'hFFFE, S_RAM,  1'b0},  // R3 run: no flip
        {4'd2,  2'b01, 16'hFFFE, 16'hFEFE, S_RAM,  1'b0},  // R2 reset vector fetch
        {4'd2,  2'b01, 16'hFFF8, 16'hFEF8, S_RAM,  1'b0},  // R2 IRQ vector fetch
        {4'd2,  2'b01, 16'hFFF0, 16'hFEF0, S_RAM,  1'b0},  // R2 window bottom
        {4'd4,  2'b01, 16'hFFEF, 16'hFFEF, S_RAM,  1'b0},  // R4 just below the window
        {4'd3,  2'b10, 16'hFFFC, 16'hFFFC, S_RAM,  1'b0},  // R3 sync: no flip
        {4'd1,  2'b10, 16'hFFF8, 16'hFFF8, S_RAM,  1'b0},  // R1 sync decodes as run
        {4'd5,  2'b00, 16'hFEF8, 16'hFEF8, S_HOST, 1'b0},  // R5
        {4'd5,  2'b00, 16'hFEFF, 16'hFEFF, S_HOST, 1'b0},  // R5
        {4'd6,  2'b00, 16'hFEF0, 16'hFEF0, S_IO,   1'b0},  // R6
        {4'd6,  2'b00, 16'hFEF7, 16'hFEF7, S_IO,   1'b0},  // R6
        {4'd5,  2'b10, 16'hFEF9, 16'hFEF9, S_HOST, 1'b0},  // R5 in sync
        {4'd3,  2'b01, 16'hFEF4, 16'hFEF4, S_IO,   1'b0},  // R3 vector state outside window
        {4'd9,  2'b11, 16'hFFFE, 16'hFFFE, S_NONE, 1'b1},  // R9 bus grant
        {4'd9,  2'b11, 16'hFEF9, 16'hFEF9, S_NONE, 1'b1},  // R9 bus grant in I/O page
        {4'd10, 2'b00, 16'h1234, 16'h1234, S_RAM,  1'b0},  // R10
        {4'd10, 2'b00, 16'hFEEF, 16'hFEEF, S_RAM,  1'b0},  // R10 below I/O page
        {4'd10, 2'b00, 16'hFF00, 16'hFF00, S_RAM,  1'b0}   // R10 between the pages
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic        cpu_wbit = 1'b0;
    logic        cycle_valid = 1'b0;
    logic        bus_avail = 1'b0;
    logic        bus_stat = 1'b0;
    logic [15:0] ram_addr;
    logic        ram_sel, io_sel, host_sel, bus_released;

    int vectors = 0;
    int miss = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vecpull_remap uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_addr     (cpu_addr),
        .cpu_rnw      (cpu_rnw),
        .cpu_wbit     (cpu_wbit),
        .cycle_valid  (cycle_valid),
        .bus_avail    (bus_avail),
        .bus_stat     (bus_stat),
        .ram_addr     (ram_addr),
        .ram_sel      (ram_sel),
        .io_sel       (io_sel),
        .host_sel     (host_sel),
        .bus_released (bus_released)
    );

    // Drive a read access on a falling edge and compare the combinational outputs.
    task automatic apply(input logic [1:0] st, input logic [15:0] a, input logic [15:0] ea,
                         input logic [2:0] es, input logic er, input string tag);
        @(negedge clk);
        {bus_avail, bus_stat} = st;
        cpu_addr    = a;
        cpu_rnw     = 1'b1;
        cycle_valid = 1'b1;
        #1;
        vectors++;
        if (ram_addr !== ea || {ram_sel, io_sel, host_sel} !== es || bus_released !== er) begin
            miss++;
            $display("FAIL %s: addr=%h got ram_addr=%h sel=%b rel=%b, expected ram_addr=%h sel=%b rel=%b",
                     tag, a, ram_addr, {ram_sel, io_sel, host_sel}, bus_released, ea, es, er);
        end
    endtask

    // Present a write (or read) cycle for one rising edge, then return to idle.
    task automatic cycle(input logic [1:0] st, input logic [15:0] a, input logic rnw,
                         input logic wbit, input logic valid);
        @(negedge clk);
        {bus_avail, bus_stat} = st;
        cpu_addr    = a;
        cpu_rnw     = rnw;
        cpu_wbit    = wbit;
        cycle_valid = valid;
        @(negedge clk);
        cpu_rnw     = 1'b1;
        cycle_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: control bit clear after reset, so the I/O page is I/O.
        apply(2'b00, 16'hFEF3, 16'hFEF3, S_IO, 1'b0, "R7 reset value");

        for (int i = 0; i < NVEC; i++) begin
            apply(TABLE[i][37:36], TABLE[i][35:20], TABLE[i][19:4], TABLE[i][3:1], TABLE[i][0],
                  $sformatf("R%0d table entry %0d", TABLE[i][41:38], i));
        end

        // R7/R8: set the control bit; the page now reaches RAM for vector editing.
        cycle(2'b00, 16'hFEF0, 1'b0, 1'b1, 1'b1);
        apply(2'b00, 16'hFEF3, 16'hFEF3, S_RAM, 1'b0, "R8 edit io half");
        apply(2'b00, 16'hFEFE, 16'hFEFE, S_RAM, 1'b0, "R8 edit vector slot");
        apply(2'b01, 16'hFFFA, 16'hFEFA, S_RAM, 1'b0, "R2 fetch with edit bit set");
        apply(2'b11, 16'hFEFE, 16'hFEFE, S_NONE, 1'b1, "R9 release overrides edit bit");

        // R11: a read of the register address leaves the bit set.
        cycle(2'b00, 16'hFEF0, 1'b1, 1'b0, 1'b1);
        apply(2'b00, 16'hFEF5, 16'hFEF5, S_RAM, 1'b0, "R11 read ignored");

        // R7: unqualified writes are ignored.
        cycle(2'b00, 16'hFEF0, 1'b0, 1'b0, 1'b0);
        apply(2'b00, 16'hFEF5, 16'hFEF5, S_RAM, 1'b0, "R7 write without cycle_valid");
        cycle(2'b11, 16'hFEF0, 1'b0, 1'b0, 1'b1);
        apply(2'b00, 16'hFEF5, 16'hFEF5, S_RAM, 1'b0, "R7 write while released");
        cycle(2'b01, 16'hFEF0, 1'b0, 1'b0, 1'b1);
        apply(2'b00, 16'hFEF5, 16'hFEF5, S_RAM, 1'b0, "R7 write during vector fetch");
        cycle(2'b00, 16'hFEF1, 1'b0, 1'b0, 1'b1);
        apply(2'b00, 16'hFEF5, 16'hFEF5, S_RAM, 1'b0, "R7 write to neighbour address");

        // R7/R1: a write during sync acknowledge is qualified and clears the bit.
        cycle(2'b10, 16'hFEF0, 1'b0, 1'b0, 1'b1);
        apply(2'b00, 16'hFEF5, 16'hFEF5, S_IO, 1'b0, "R7 clear in sync state");
        apply(2'b00, 16'hFEFB, 16'hFEFB, S_HOST, 1'b0, "R5 after clear");

        // R7: reset clears a set bit.
        cycle(2'b00, 16'hFEF0, 1'b0, 1'b1, 1'b1);
        apply(2'b00, 16'hFEF2, 16'hFEF2, S_RAM, 1'b0, "R8 set again");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(2'b00, 16'hFEF2, 16'hFEF2, S_IO, 1'b0, "R7 reset clears bit");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

endmodule